// File: doc/BRIEF.md
# MCU-Loadable Output Macrocell Bank

This block holds sixteen registered output cells split into two groups of eight, A and B. In normal operation each cell is a flip-flop on the system clock. Its next state comes from logic-side inputs: a synchronous clear, a synchronous preset and a clock-enabled data input. A microcontroller can also reach the bank through a small byte-wide register window. The window has a select, a 3-bit offset, write data, and active-low write and read strobes. Through it the microcontroller can overwrite either group, read both groups back, program one protect mask per group, and program a 16-bit direction register.

The write strobe is sampled in the clock domain. A write commits on the clock after the strobe is first seen high again, which is the trailing edge of the strobe. For the cells it targets, the write takes precedence over clear, preset and enable. A mask bit at 1 protects its cell, so a state machine built from logic-owned cells keeps running through bus writes. Each pin driver enable combines a logic-supplied enable term with the direction bit. A pin that has no configured enable term is always driven.

Top module: `omc_bank`

## Requirements
- R1: A synchronous active-high reset clears every cell, both masks and the direction register. After reset, every readable offset returns 00h.
- R2: With no bus write committing, each cell takes its next state in this priority order: clear (to 0), then preset (to 1), then enable (load data input). If none of these is asserted, the cell holds its value.
- R3: A write to offset 0 loads group A (bit i to cell Ai) and a write to offset 1 loads group B (bit i to cell Bi). The new value is visible on the second rising clock edge at which the write strobe is sampled high after being low.
- R4: For unmasked cells, a committing bus write overrides clear, preset and enable in that cycle.
- R5: Offset 2 holds the mask of group A and offset 3 holds the mask of group B. A mask bit at 1 keeps the bus write off that cell, and the cell follows its logic inputs as in R2.
- R6: A write happens only at the trailing edge of the strobe, and only if the select was high while the strobe was low. The values present in the last low-sampled cycle are used. No cell or register changes while the strobe stays low.
- R7: While select is high and the read strobe is low, the read data is the current content of the register at the offset. The offsets are 0/1 for group data, 2/3 for the masks, 4 for direction bits 7:0 and 5 for direction bits 15:8. Otherwise the read data is 00h.
- R8: A read in the cycle in which a write commits returns the value from before that write.
- R9: The enable of pin i is asserted when direction bit i is 1, or when the pin has no configured enable term, or when it has one and the term is 1.
- R10: Writes to offsets 6 and 7 change nothing, and reads of those offsets return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register window select |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_re_n | input | 1 | Read strobe, active low |
| bus_rdata | output | 8 | Read data |
| lg_d | input | 16 | Logic-side data input per cell (A0..A7 then B0..B7) |
| lg_ce | input | 16 | Logic-side clock enable per cell |
| lg_set | input | 16 | Logic-side synchronous preset per cell |
| lg_clr | input | 16 | Logic-side synchronous clear per cell |
| oe_term | input | 16 | Logic-supplied driver enable term per pin |
| oe_cfg | input | 16 | 1 where a pin has a configured enable term |
| cell_q | output | 16 | Cell outputs, bit 0 = A0, bit 15 = B7 |
| pin_oe | output | 16 | Pin driver enables |

## Verification
The hardest situation to reach is a bus write that commits while the logic inputs are active on the same cells, with some of those cells masked and others not. The stimulus holds preset and clear asserted across the whole write sequence. The logic term therefore acts in the cycle before the commit, the write overrides it on unmasked bits in the commit cycle, and masked bits show the logic value. The stimulus also places a read in the exact commit cycle, and a strobe held low for several cycles while its data changes, to exercise the edge timing.

// File: rtl/omc_pkg.sv
package omc_pkg;

    localparam int ADDR_W = 3;
    localparam int N_GRP  = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DATA_A = 3'd0,
        OFF_DATA_B = 3'd1,
        OFF_MASK_A = 3'd2,
        OFF_MASK_B = 3'd3,
        OFF_DIR_L  = 3'd4,
        OFF_DIR_H  = 3'd5,
        OFF_RSV_6  = 3'd6,
        OFF_RSV_7  = 3'd7
    } reg_off_e;

    localparam logic [ADDR_W-1:0] DATA_BASE = OFF_DATA_A;
    localparam logic [ADDR_W-1:0] MASK_BASE = OFF_MASK_A;
    localparam logic [ADDR_W-1:0] DIR_BASE  = OFF_DIR_L;

    // target of a captured bus write
    typedef struct packed {
        logic     sel;
        reg_off_e off;
    } bus_tgt_t;

    // next state of one cell: bus load first, then clear, preset, enable
    function automatic logic cell_next(
        input logic ld, input logic ld_v,
        input logic clr, input logic set,
        input logic ce, input logic d, input logic q);
        if (ld)       return ld_v;
        else if (clr) return 1'b0;
        else if (set) return 1'b1;
        else if (ce)  return d;
        else          return q;
    endfunction

endpackage

// File: rtl/omc_wr_sync.sv
module omc_wr_sync
    import omc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we_n,
    output logic              wr_fire,
    output bus_tgt_t          wr_tgt,
    output logic [DW-1:0]     wr_data
);

    logic we_s1, we_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_s1 <= 1'b1;
            we_s2 <= 1'b1;
        end else begin
            we_s1 <= bus_we_n;
            we_s2 <= we_s1;
        end
    end

    // hold the last values seen while the strobe is low
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_tgt  <= '{sel: 1'b0, off: OFF_DATA_A};
            wr_data <= '0;
        end else if (!bus_we_n) begin
            wr_tgt  <= '{sel: bus_sel, off: reg_off_e'(bus_addr)};
            wr_data <= bus_wdata;
        end
    end

    assign wr_fire = we_s1 & ~we_s2;

endmodule

// File: rtl/omc_cell_grp.sv
module omc_cell_grp
    import omc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_data,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] lg_d,
    input  logic [W-1:0] lg_ce,
    input  logic [W-1:0] lg_set,
    input  logic [W-1:0] lg_clr,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_ld;
        assign bit_ld = ld_en & ~mask[i];
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= cell_next(bit_ld, ld_data[i], lg_clr[i],
                                       lg_set[i], lg_ce[i], lg_d[i], q[i]);
        end
    end

endmodule

// File: rtl/omc_oe_gen.sv
module omc_oe_gen #(
    parameter int N = 16
) (
    input  logic [N-1:0] oe_term,
    input  logic [N-1:0] oe_cfg,
    input  logic [N-1:0] dir,
    output logic [N-1:0] pin_oe
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            if (dir[i])        pin_oe[i] = 1'b1;
            else if (!oe_cfg[i]) pin_oe[i] = 1'b1;
            else               pin_oe[i] = oe_term[i];
        end
    end

endmodule

// File: rtl/omc_bank.sv
module omc_bank
    import omc_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int N_CELL = N_GRP * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GRP_W-1:0]  bus_wdata,
    input  logic              bus_we_n,
    input  logic              bus_re_n,
    output logic [GRP_W-1:0]  bus_rdata,
    input  logic [N_CELL-1:0] lg_d,
    input  logic [N_CELL-1:0] lg_ce,
    input  logic [N_CELL-1:0] lg_set,
    input  logic [N_CELL-1:0] lg_clr,
    input  logic [N_CELL-1:0] oe_term,
    input  logic [N_CELL-1:0] oe_cfg,
    output logic [N_CELL-1:0] cell_q,
    output logic [N_CELL-1:0] pin_oe
);

    logic                              wr_fire;
    bus_tgt_t                          wr_tgt;
    logic [GRP_W-1:0]                  wr_data;
    logic [N_GRP-1:0][GRP_W-1:0]       grp_q;
    logic [N_GRP-1:0][GRP_W-1:0]       mask_q;
    logic [N_GRP-1:0][GRP_W-1:0]       dir_q;

    omc_wr_sync #(.DW(GRP_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we_n (bus_we_n),
        .wr_fire  (wr_fire),
        .wr_tgt   (wr_tgt),
        .wr_data  (wr_data)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic ld_cell, ld_mask, ld_dir;
        assign ld_cell = wr_fire & wr_tgt.sel & (wr_tgt.off == reg_off_e'(DATA_BASE + ADDR_W'(g)));
        assign ld_mask = wr_fire & wr_tgt.sel & (wr_tgt.off == reg_off_e'(MASK_BASE + ADDR_W'(g)));
        assign ld_dir  = wr_fire & wr_tgt.sel & (wr_tgt.off == reg_off_e'(DIR_BASE  + ADDR_W'(g)));

        omc_cell_grp #(.W(GRP_W)) u_cells (
            .clk    (clk),
            .rst    (rst),
            .ld_en  (ld_cell),
            .ld_data(wr_data),
            .mask   (mask_q[g]),
            .lg_d   (lg_d  [g*GRP_W +: GRP_W]),
            .lg_ce  (lg_ce [g*GRP_W +: GRP_W]),
            .lg_set (lg_set[g*GRP_W +: GRP_W]),
            .lg_clr (lg_clr[g*GRP_W +: GRP_W]),
            .q      (grp_q[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= '0;
                dir_q[g]  <= '0;
            end else begin
                if (ld_mask) mask_q[g] <= wr_data;
                if (ld_dir)  dir_q[g]  <= wr_data;
            end
        end
    end

    // readback from current state (pre-write within a commit cycle)
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_re_n) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (bus_addr == DATA_BASE + ADDR_W'(g)) bus_rdata = grp_q[g];
                if (bus_addr == MASK_BASE + ADDR_W'(g)) bus_rdata = mask_q[g];
                if (bus_addr == DIR_BASE  + ADDR_W'(g)) bus_rdata = dir_q[g];
            end
        end
    end

    assign cell_q = grp_q;

    omc_oe_gen #(.N(N_CELL)) u_oe (
        .oe_term(oe_term),
        .oe_cfg (oe_cfg),
        .dir    (dir_q),
        .pin_oe (pin_oe)
    );

endmodule

// File: rtl/omc_bank_chk.sv
module omc_bank_chk
    import omc_pkg::*;
#(
    parameter int GRP_W = 8,
    localparam int N_CELL = 2 * GRP_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_fire,
    input bus_tgt_t          wr_tgt,
    input logic [GRP_W-1:0]  wr_data,
    input logic [GRP_W-1:0]  mask_a,
    input logic [GRP_W-1:0]  mask_b,
    input logic [N_CELL-1:0] dir,
    input logic [N_CELL-1:0] lg_d,
    input logic [N_CELL-1:0] lg_ce,
    input logic [N_CELL-1:0] lg_set,
    input logic [N_CELL-1:0] lg_clr,
    input logic [N_CELL-1:0] oe_term,
    input logic [N_CELL-1:0] oe_cfg,
    input logic              bus_re_n,
    input logic [GRP_W-1:0]  bus_rdata,
    input logic [N_CELL-1:0] cell_q,
    input logic [N_CELL-1:0] pin_oe
);

    logic ld_a, ld_b;
    assign ld_a = wr_fire && wr_tgt.sel && wr_tgt.off == OFF_DATA_A;
    assign ld_b = wr_fire && wr_tgt.sel && wr_tgt.off == OFF_DATA_B;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cell_q == '0 && mask_a == '0 && mask_b == '0 && dir == '0)); // R1

    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> (cell_q & $past(lg_clr)) == '0); // R2

    AST_PRESET_SECOND: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> (~cell_q & $past(lg_set & ~lg_clr)) == '0); // R2

    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> ((cell_q ^ $past(lg_d)) & $past(lg_ce & ~lg_set & ~lg_clr)) == '0); // R2

    AST_LOAD_A_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> (cell_q[GRP_W-1:0] & ~$past(mask_a)) == ($past(wr_data) & ~$past(mask_a))); // R4

    AST_LOAD_B_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_b |=> (cell_q[N_CELL-1:GRP_W] & ~$past(mask_b)) == ($past(wr_data) & ~$past(mask_b))); // R4

    AST_MASK_HOLDS_A: assert property (@(posedge clk) disable iff (rst)
        ld_a |=> ((cell_q[GRP_W-1:0] ^ $past(cell_q[GRP_W-1:0]))
                  & $past(mask_a & ~lg_clr[GRP_W-1:0] & ~lg_set[GRP_W-1:0] & ~lg_ce[GRP_W-1:0])) == '0); // R5

    AST_CFG_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> ($stable(mask_a) && $stable(mask_b) && $stable(dir))); // R6

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        bus_re_n |-> bus_rdata == '0); // R7

    AST_OE_DIR_FORCES: assert property (@(posedge clk) disable iff (rst)
        (dir & ~pin_oe) == '0); // R9

    AST_OE_UNCFG_ON: assert property (@(posedge clk) disable iff (rst)
        (~oe_cfg & ~pin_oe) == '0); // R9

    AST_OE_TERM_ON: assert property (@(posedge clk) disable iff (rst)
        (oe_cfg & oe_term & ~pin_oe) == '0); // R9

endmodule

bind omc_bank omc_bank_chk #(.GRP_W(GRP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_fire  (wr_fire),
    .wr_tgt   (wr_tgt),
    .wr_data  (wr_data),
    .mask_a   (mask_q[0]),
    .mask_b   (mask_q[1]),
    .dir      (dir_q),
    .lg_d     (lg_d),
    .lg_ce    (lg_ce),
    .lg_set   (lg_set),
    .lg_clr   (lg_clr),
    .oe_term  (oe_term),
    .oe_cfg   (oe_cfg),
    .bus_re_n (bus_re_n),
    .bus_rdata(bus_rdata),
    .cell_q   (cell_q),
    .pin_oe   (pin_oe)
);

// File: tb/omc_bank_bench.sv
module omc_bank_bench;

    localparam int W = 8;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_sel, bus_we_n, bus_re_n;
    logic [2:0]   bus_addr;
    logic [W-1:0] bus_wdata, bus_rdata;
    logic [N-1:0] lg_d, lg_ce, lg_set, lg_clr, oe_term, oe_cfg, cell_q, pin_oe;

    always #10 clk = ~clk;

    omc_bank u_omc_bank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we_n(bus_we_n), .bus_re_n(bus_re_n),
        .bus_rdata(bus_rdata), .lg_d(lg_d), .lg_ce(lg_ce), .lg_set(lg_set),
        .lg_clr(lg_clr), .oe_term(oe_term), .oe_cfg(oe_cfg),
        .cell_q(cell_q), .pin_oe(pin_oe)
    );

    typedef struct {
        string       req;
        int          kind;   // 0 cell_q, 1 bus_rdata, 2 pin_oe
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = cell_q;
                    1:       act = {8'h00, bus_rdata};
                    default: act = pin_oe;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string req, input int kind, input logic [15:0] exp);
        q.push_back('{req: req, kind: kind, exp: exp});
        -> chk_ev;
        #1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_addr = a; bus_wdata = d; bus_we_n = 1'b0;
        @(negedge clk);
        bus_we_n = 1'b1; bus_sel = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_re_n = 1'b0;
        #1;
        expect_item(req, 1, {8'h00, exp});
        @(negedge clk);
        bus_sel = 1'b0; bus_re_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_we_n = 1'b1; bus_re_n = 1'b1;
        bus_addr = '0; bus_wdata = '0;
        lg_d = '0; lg_ce = '0; lg_set = '0; lg_clr = '0;
        oe_term = '0; oe_cfg = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_item("R1", 0, 16'h0000);
        expect_item("R1", 2, 16'h0000);
        for (int a = 0; a < 6; a++) bus_read(3'(a), 8'h00, "R1");

        // R2: enable, clear over preset, preset over enable, hold
        @(negedge clk); lg_ce = '1; lg_d = 16'hA55A;
        @(negedge clk); expect_item("R2", 0, 16'hA55A);
        lg_ce = '0; lg_clr = 16'h00FF; lg_set = 16'h0F0F;
        @(negedge clk); expect_item("R2", 0, 16'hAF00);
        lg_clr = '0; lg_set = '1; lg_ce = '1; lg_d = '0;
        @(negedge clk); expect_item("R2", 0, 16'hFFFF);
        lg_set = '0; lg_ce = '0;
        @(negedge clk); expect_item("R2", 0, 16'hFFFF);
        lg_clr = '1;
        @(negedge clk); expect_item("R2", 0, 16'h0000);
        lg_clr = '0;

        // R3, R7: group loads and readback
        bus_write(3'd0, 8'h3C, 1'b1);
        expect_item("R3", 0, 16'h003C);
        bus_write(3'd1, 8'hC3, 1'b1);
        expect_item("R3", 0, 16'hC33C);
        bus_read(3'd0, 8'h3C, "R7");
        bus_read(3'd1, 8'hC3, "R7");

        // R8: read in the commit cycle sees old value
        @(negedge clk); bus_sel = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h55; bus_we_n = 1'b0;
        @(negedge clk); bus_we_n = 1'b1; bus_sel = 1'b0;
        @(posedge clk);
        @(negedge clk); bus_sel = 1'b1; bus_addr = 3'd0; bus_re_n = 1'b0;
        #1; expect_item("R8", 1, 16'h003C);
        @(negedge clk); expect_item("R8", 1, 16'h0055);
        bus_sel = 1'b0; bus_re_n = 1'b1;
        #1; expect_item("R7", 1, 16'h0000);

        // R5: mask A protects low nibble
        bus_write(3'd2, 8'h0F, 1'b1);
        bus_read(3'd2, 8'h0F, "R5");
        bus_write(3'd0, 8'hFF, 1'b1);
        expect_item("R5", 0, 16'hC3F5);
        // masked bit follows preset, unmasked preset is overridden (R4)
        lg_set = 16'h0012;
        bus_write(3'd0, 8'h00, 1'b1);
        expect_item("R5", 0, 16'hC307);
        lg_set = '0;

        // R4: bus write beats clear on group B
        lg_clr = '1;
        bus_write(3'd1, 8'hA5, 1'b1);
        expect_item("R4", 0, 16'hA500);
        lg_clr = '0;

        // R6: long strobe, last data wins, no change while low
        @(negedge clk); bus_sel = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h11; bus_we_n = 1'b0;
        @(negedge clk); bus_wdata = 8'h22;
        @(negedge clk); bus_wdata = 8'h3E;
        @(negedge clk); expect_item("R6", 0, 16'hA500);
        bus_we_n = 1'b1; bus_sel = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        expect_item("R6", 0, 16'h3E00);
        bus_write(3'd1, 8'h00, 1'b0);
        expect_item("R6", 0, 16'h3E00);

        // R10: reserved offsets
        bus_write(3'd6, 8'hFF, 1'b1);
        bus_write(3'd7, 8'hFF, 1'b1);
        expect_item("R10", 0, 16'h3E00);
        bus_read(3'd2, 8'h0F, "R10");
        bus_read(3'd3, 8'h00, "R10");
        bus_read(3'd4, 8'h00, "R10");
        bus_read(3'd5, 8'h00, "R10");
        bus_read(3'd6, 8'h00, "R10");
        bus_read(3'd7, 8'h00, "R10");

        // R9: output enables
        @(negedge clk); oe_term = 16'h1234;
        #1; expect_item("R9", 2, 16'h1234);
        bus_write(3'd4, 8'h0F, 1'b1);
        bus_write(3'd5, 8'h80, 1'b1);
        expect_item("R9", 2, 16'h923F);
        bus_read(3'd4, 8'h0F, "R7");
        bus_read(3'd5, 8'h80, "R7");
        @(negedge clk); oe_cfg = 16'h00FF; oe_term = '0;
        #1; expect_item("R9", 2, 16'hFF0F);

        // R7: read strobe without select
        @(negedge clk); bus_addr = 3'd1; bus_re_n = 1'b0;
        #1; expect_item("R7", 1, 16'h0000);
        bus_re_n = 1'b1;

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule